// File: doc/BRIEF.md
# Selectable-convention binary64 minimum/maximum unit

This block picks the smaller or the larger of two IEEE-754 binary64 operands. A 4-bit mode word chooses among four ways of treating NaN inputs, between minimum and maximum, and between signed and magnitude ordering. The selection logic is purely combinational. One register stage follows it and holds the result together with the floating-point status that the operation produces.

The status stage raises a flag when either operand is a signalling NaN. That flag sets a sticky invalid bit, and the exception summary bit is set on that bit's first transition. When invalid-operation traps are enabled and a signalling NaN is present, the stage suppresses the destination write and requests a trap instead. If the caller asks for the recorded form, the stage also emits a 4-bit condition field built from the status bits.

A pipeline issues at most one operation per cycle on `in_valid`. Every response appears on the outputs exactly one clock later.

Top module: `fmm_unit`

## Requirements
- R1: An operand is a NaN when bits 62:52 are all ones and bits 51:0 are not all zero. It is signalling when bit 51 is 0, and quieting means forcing bit 51 to 1. `out_snan` is 1 exactly when either operand is a signalling NaN.
- R2: Convention 00 (mode bits 1:0) applies these rules in order, when any NaN is present: an sNaN in A returns quieted A; otherwise an sNaN in B returns quieted B; two NaNs return quieted A; a single NaN returns the other operand unchanged.
- R3: Convention 01 returns a quiet NaN whenever either input is a NaN: quieted A if A is a NaN, otherwise quieted B.
- R4: Convention 10 returns quieted A when both inputs are NaN, and otherwise returns the non-NaN operand unchanged when one input is NaN.
- R5: Convention 11 returns operand B unchanged when either input is a NaN, and also when both inputs are zeros of any sign.
- R6: In conventions 00, 01 and 10, when both inputs are zeros, maximum returns the bitwise AND of A and B and minimum returns their bitwise OR, so +0 ranks above -0.
- R7: For two non-NaN inputs that are not both zero, mode bit 3 = 1 returns the numerically larger operand and bit 3 = 0 the smaller one. When neither operand is strictly preferred, B is returned.
- R8: With mode bit 2 = 1, operands are ordered by absolute value. When the absolute values are equal, the signed order of R7 decides.
- R9: A signalling-NaN operation sets the sticky invalid bit. The summary bit is set only when the sticky invalid bit was clear before that operation. Both bits stay set until reset.
- R10: With `inv_trap_en` = 1 and a signalling NaN present, `out_trap` is 1 and `out_write` is 0. In every other accepted operation `out_write` is 1, `out_trap` is 0, and `out_result` carries the selected value.
- R11: When `in_record` is 1, `out_cond_wr` is 1 and `out_cond` is {summary, invalid AND trap enable, invalid, 0} from bit 3 down to bit 0. The bits are taken after this operation's update.
- R12: After reset all outputs are 0. Each accepted operation produces exactly one response with `out_valid` = 1 on the clock edge following the one that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_mode | input | 4 | [3] max, [2] magnitude, [1:0] NaN convention |
| in_record | input | 1 | Request condition field update |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Response present |
| out_result | output | 64 | Selected value (meaningful when out_write) |
| out_write | output | 1 | Destination write enable |
| out_trap | output | 1 | Trap request |
| out_snan | output | 1 | A signalling NaN was seen |
| out_cond_wr | output | 1 | Condition field write enable |
| out_cond | output | 4 | Condition field |
| sticky_invalid | output | 1 | Sticky signalling-NaN invalid bit |
| sticky_summary | output | 1 | Sticky exception summary bit |

## Verification
Every field of a response, including the sticky bits, is due on the first rising edge after the edge that accepted the operation. The driver applies operands just after a falling edge and pushes the expected response into a queue in issue order. The monitor pops one entry at each later falling edge where `out_valid` is high, so each comparison takes place half a cycle after the register stage has updated. Any entry still queued when the run drains marks a missing response.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    localparam int FP_W    = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int QBIT    = FRAC_W - 1;
    localparam int MODE_W  = 4;
    localparam int COND_W  = 4;
    localparam int NUM_OPS = 2;

    typedef enum logic [1:0] {
        CONV_NUM08 = 2'b00,
        CONV_MIN19 = 2'b01,
        CONV_NUM19 = 2'b10,
        CONV_CLIB  = 2'b11
    } conv_e;

    typedef struct packed {
        logic            nan;
        logic            snan;
        logic            zero;
        logic [FP_W-1:0] quiet;
    } opinfo_t;

    typedef struct packed {
        logic              out_valid;
        logic              wr;
        logic              trap;
        logic              snan;
        logic              cond_wr;
        logic [COND_W-1:0] cond;
        logic [FP_W-1:0]   result;
        logic              vx;
        logic              fx;
    } state_t;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
(
    input  logic [FP_W-1:0] x,
    output opinfo_t         info
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones       = &x[FP_W-2 -: EXP_W];
        frac_nz        = |x[FRAC_W-1:0];
        info.nan       = exp_ones & frac_nz;
        info.snan      = exp_ones & frac_nz & ~x[QBIT];
        info.zero      = ~|x[FP_W-2:0];
        info.quiet     = x;
        info.quiet[QBIT] = 1'b1;
    end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
    import fmm_pkg::*;
(
    input  logic [FP_W-1:0]   a,
    input  logic [FP_W-1:0]   b,
    input  opinfo_t           ia,
    input  opinfo_t           ib,
    input  logic [MODE_W-1:0] mode,
    output logic [FP_W-1:0]   result,
    output logic              any_snan
);
    // Monotonic ordering key: negative values invert every bit,
    // non-negative values flip the sign bit.
    function automatic logic [FP_W-1:0] order_key(input logic [FP_W-1:0] x);
        return x[FP_W-1] ? ~x : {1'b1, x[FP_W-2:0]};
    endfunction

    conv_e           conv;
    logic            take_max;
    logic            use_mag;
    logic [FP_W-1:0] ka;
    logic [FP_W-1:0] kb;
    logic            a_wins;

    always_comb begin
        conv     = conv_e'(mode[1:0]);
        take_max = mode[3];
        use_mag  = mode[2] && (a[FP_W-2:0] != b[FP_W-2:0]);
        ka       = use_mag ? {1'b1, a[FP_W-2:0]} : order_key(a);
        kb       = use_mag ? {1'b1, b[FP_W-2:0]} : order_key(b);
        a_wins   = take_max ? (ka > kb) : (ka < kb);
        any_snan = ia.snan | ib.snan;

        result = a_wins ? a : b;
        if (ia.zero && ib.zero) begin
            if (conv == CONV_CLIB) result = b;
            else                   result = take_max ? (a & b) : (a | b);
        end
        if (ia.nan || ib.nan) begin
            unique case (conv)
                CONV_NUM08: begin
                    if (ia.snan)                result = ia.quiet;
                    else if (ib.snan)           result = ib.quiet;
                    else if (ia.nan && ib.nan)  result = ia.quiet;
                    else if (ia.nan)            result = b;
                    else                        result = a;
                end
                CONV_MIN19: result = ia.nan ? ia.quiet : ib.quiet;
                CONV_NUM19: begin
                    if (ia.nan && ib.nan)       result = ia.quiet;
                    else if (ia.nan)            result = b;
                    else                        result = a;
                end
                default:    result = b;
            endcase
        end
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   in_a,
    input  logic [FP_W-1:0]   in_b,
    input  logic [MODE_W-1:0] in_mode,
    input  logic              in_record,
    input  logic              inv_trap_en,
    output logic              out_valid,
    output logic [FP_W-1:0]   out_result,
    output logic              out_write,
    output logic              out_trap,
    output logic              out_snan,
    output logic              out_cond_wr,
    output logic [COND_W-1:0] out_cond,
    output logic              sticky_invalid,
    output logic              sticky_summary
);
    logic [FP_W-1:0] ops [NUM_OPS];
    opinfo_t         infos [NUM_OPS];
    logic [FP_W-1:0] sel_result;
    logic            sel_snan;
    state_t          s_d, s_q;

    assign ops[0] = in_a;
    assign ops[1] = in_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fmm_classify u_cls (.x(ops[g]), .info(infos[g]));
    end

    fmm_select u_sel (
        .a(in_a), .b(in_b), .ia(infos[0]), .ib(infos[1]),
        .mode(in_mode), .result(sel_result), .any_snan(sel_snan)
    );

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = in_valid;
        s_d.wr        = 1'b0;
        s_d.trap      = 1'b0;
        s_d.snan      = 1'b0;
        s_d.cond_wr   = 1'b0;
        if (in_valid) begin
            s_d.result = sel_result;
            s_d.snan   = sel_snan;
            s_d.trap   = sel_snan & inv_trap_en;
            s_d.wr     = ~(sel_snan & inv_trap_en);
            if (sel_snan) begin
                s_d.vx = 1'b1;
                if (!s_q.vx) s_d.fx = 1'b1;
            end
            s_d.cond_wr = in_record;
            s_d.cond    = {s_d.fx, s_d.vx & inv_trap_en, s_d.vx, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid      = s_q.out_valid;
    assign out_result     = s_q.result;
    assign out_write      = s_q.wr;
    assign out_trap       = s_q.trap;
    assign out_snan       = s_q.snan;
    assign out_cond_wr    = s_q.cond_wr;
    assign out_cond       = s_q.cond;
    assign sticky_invalid = s_q.vx;
    assign sticky_summary = s_q.fx;

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_invalid |=> sticky_invalid);
    assert_summary_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_summary) |-> $rose(sticky_invalid));
    assert_trap_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (!out_write && sticky_invalid && out_snan));
    assert_min19_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[1:0] == 2'b01 && (infos[0].nan || infos[1].nan))
        |=> ((&out_result[FP_W-2 -: EXP_W]) && out_result[QBIT]));
    assert_one_response_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: tb/fmm_unit_bench.sv
module fmm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic [3:0]  in_mode = '0;
    logic        in_record = 1'b0, inv_trap_en = 1'b0;
    logic        out_valid, out_write, out_trap, out_snan, out_cond_wr;
    logic [63:0] out_result;
    logic [3:0]  out_cond;
    logic        sticky_invalid, sticky_summary;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [63:0] res;
        logic wr, trap, snan, cond_wr;
        logic [3:0] cond;
        logic vx, fx;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];
    bit m_vx, m_fx;

    always #2 clk = ~clk;

    fmm_unit u_fmm_unit (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] tval(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h8000_0000_0000_0000;
            2:  return 64'h3FF0_0000_0000_0000;
            3:  return 64'hBFF0_0000_0000_0000;
            4:  return 64'h4000_0000_0000_0000;
            5:  return 64'hBFF8_0000_0000_0000;
            6:  return 64'h3FF8_0000_0000_0000;
            7:  return 64'h7FF0_0000_0000_0000;
            8:  return 64'hFFF0_0000_0000_0000;
            9:  return 64'h7FF8_0000_0000_0000;
            10: return 64'hFFF8_0000_0000_0001;
            11: return 64'h7FF0_0000_0000_0001;
            12: return 64'hFFF4_0000_0000_0000;
            13: return 64'h0000_0000_0000_0001;
            14: return 64'h8000_0000_0000_0003;
            default: return 64'h7FEF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic bit is_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [63:0] x);
        return is_nan(x) && !x[51];
    endfunction
    function automatic logic [63:0] qn(input logic [63:0] x);
        return x | 64'h0008_0000_0000_0000;
    endfunction
    function automatic bit is_zero(input logic [63:0] x);
        return x[62:0] == 0;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, b, input logic [3:0] m);
        real ra, rb, xa, xb;
        bit an, bn, pick_a;
        an = is_nan(a); bn = is_nan(b);
        if (an || bn) begin
            case (m[1:0])
                2'b00: begin
                    if (is_snan(a)) return qn(a);
                    if (is_snan(b)) return qn(b);
                    if (an && bn) return qn(a);
                    return an ? b : a;
                end
                2'b01: return an ? qn(a) : qn(b);
                2'b10: begin
                    if (an && bn) return qn(a);
                    return an ? b : a;
                end
                default: return b;
            endcase
        end
        if (is_zero(a) && is_zero(b)) begin
            if (m[1:0] == 2'b11) return b;
            return m[3] ? (a & b) : (a | b);
        end
        ra = $bitstoreal(a); rb = $bitstoreal(b);
        xa = ra; xb = rb;
        if (m[2]) begin
            xa = (ra < 0.0) ? -ra : ra;
            xb = (rb < 0.0) ? -rb : rb;
            if (xa == xb) begin xa = ra; xb = rb; end
        end
        pick_a = m[3] ? (xa > xb) : (xa < xb);
        return pick_a ? a : b;
    endfunction

    function automatic string res_tag(input logic [63:0] a, b, input logic [3:0] m);
        if (is_nan(a) || is_nan(b))
            case (m[1:0])
                2'b00: return "R2";
                2'b01: return "R3";
                2'b10: return "R4";
                default: return "R5";
            endcase
        if (is_zero(a) && is_zero(b)) return (m[1:0] == 2'b11) ? "R5" : "R6";
        return m[2] ? "R8" : "R7";
    endfunction

    task automatic drive(input logic [63:0] a, b, input logic [3:0] m, input bit rec);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_mode = m; in_record = rec;
        e.res  = model(a, b, m);
        e.snan = is_snan(a) || is_snan(b);
        e.trap = e.snan && inv_trap_en;
        e.wr   = !e.trap;
        if (e.snan) begin
            if (!m_vx) m_fx = 1'b1;
            m_vx = 1'b1;
        end
        e.vx = m_vx; e.fx = m_fx;
        e.cond_wr = rec;
        e.cond = {m_fx, m_vx & inv_trap_en, m_vx, 1'b0};
        expq.push_back(e);
        tagq.push_back(res_tag(a, b, m));
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R12", "missing responses", 64'(expq.size()), 64'd0);
        expq.delete(); tagq.delete();
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R12", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (e.wr) check(out_result == e.res, t, "result", out_result, e.res);
                check(out_snan == e.snan, "R1", "snan flag", 64'(out_snan), 64'(e.snan));
                check({out_write, out_trap} == {e.wr, e.trap}, "R10", "write/trap",
                      64'({out_write, out_trap}), 64'({e.wr, e.trap}));
                check({sticky_invalid, sticky_summary} == {e.vx, e.fx}, "R9", "sticky",
                      64'({sticky_invalid, sticky_summary}), 64'({e.vx, e.fx}));
                check(out_cond_wr == e.cond_wr, "R11", "cond write",
                      64'(out_cond_wr), 64'(e.cond_wr));
                if (e.cond_wr) check(out_cond == e.cond, "R11", "cond field",
                                     64'(out_cond), 64'(e.cond));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        m_vx = 1'b0; m_fx = 1'b0;
        repeat (3) @(negedge clk);
        check({out_valid, out_write, out_trap, out_snan, out_cond_wr, out_cond,
               sticky_invalid, sticky_summary} == '0, "R12", "reset state",
              64'({out_valid, out_write, out_trap, out_snan, out_cond_wr, out_cond,
                   sticky_invalid, sticky_summary}), 64'd0);
        check(out_result == 64'd0, "R12", "reset result", out_result, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic sweep();
        for (int m = 0; m < 16; m++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    drive(tval(i), tval(j), 4'(m), ((i + j + m) % 2) == 0);
        drain();
    endtask

    initial begin
        do_reset();
        inv_trap_en = 1'b0;
        sweep();
        do_reset();
        inv_trap_en = 1'b1;
        sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule